// File: doc/BRIEF.md
# Dual-Clock Prefetch FIFO with Offset Flags

This block is a first-in, first-out buffer that joins a producer and a consumer running on unrelated clocks. By default it holds 1024 words of 36 bits. The write side accepts a word on each write-clock edge where the write strobe is high and the block reports it can take input. The read side works in first-word-fall-through fashion. As soon as a word is known to be present, the block loads it into a registered output stage and raises the output-ready flag, with no request from the consumer. A read strobe then consumes the shown word, and the next word, if there is one, replaces it on the same edge.

The word sitting in the output register still counts toward the total held by the block. Its memory slot has already been read out. Four registered flags describe the fill level:
- Output-ready and almost-empty belong to the read clock.
- Input-ready and almost-full belong to the write clock.

Almost-empty and almost-full are active low. Their thresholds come from two parameters: the almost-empty offset X and the almost-full offset Y. The two pointers cross between domains in Gray code through synchronizer chains of configurable length, never fewer than two flops. As a result, a flag driven by the other side's activity clears a few cycles late, but it is never raised or cleared too early in the unsafe direction.

Top module: `dcfifo_prefetch`

## Requirements
- R1: While its own domain's reset is high, and after reset with no traffic, the block shows the zero-word state: out_ready = 0, almost_empty_n = 0, almost_full_n = 1 and in_ready = 1.
- R2: When out_ready is low and a word has been written, that word appears on rdata and out_ready rises without any read strobe. This happens within a few read-clock cycles of the write.
- R3: While out_ready is high and rd_en is low, rdata does not change, even if more words are written.
- R4: Words leave through rdata in exactly the order and with exactly the values they were written. A word is consumed by a read-clock edge where rd_en and out_ready are both high.
- R5: Once both sides are settled, almost_empty_n is 0 for a total count of 0 through X and 1 for any count above X. The total count includes the word in the output register, and X is the parameter AE_OFS.
- R6: Once both sides are settled, almost_full_n is 0 for a count of DEPTH − Y or more, and 1 below that, with Y = AF_OFS. in_ready is 0 only at a count of DEPTH and is 1 at DEPTH − 1.
- R7: A write strobe while in_ready is low stores nothing. No extra word ever appears at the output.
- R8: A read strobe while out_ready is low consumes nothing. A word written later is still delivered.
- R9: Each pointer crosses to the other clock as Gray code that changes by at most one bit per source cycle. It passes through at least two synchronizing flops. A flag cleared by the other side's action may clear late.
- R10: The block stores exactly DEPTH = 2^AW words in total, counting the output register word. With default parameters that is 1024 accepted writes before in_ready falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| wrst | input | 1 | Synchronous active-high reset, write domain |
| wr_en | input | 1 | Write strobe |
| wdata | input | WIDTH | Word to store |
| in_ready | output | 1 | High when a write will be accepted |
| almost_full_n | output | 1 | Low when the count is at least DEPTH − AF_OFS |
| rclk | input | 1 | Read-side clock |
| rrst | input | 1 | Synchronous active-high reset, read domain |
| rd_en | input | 1 | Read strobe, consumes the word on rdata |
| rdata | output | WIDTH | Output register holding the oldest word |
| out_ready | output | 1 | High when rdata holds a valid word |
| almost_empty_n | output | 1 | Low when the count is AE_OFS or less |

## Verification
The assertions assume the following about the inputs:
- Both resets are applied together at start-up and held for at least SYNC_STAGES cycles of each clock, so the synchronizer chains start at zero.
- wr_en and rd_en are stable around their clock edges.
- AE_OFS and AF_OFS are no larger than DEPTH − 1.

The stimulus drives every input on the falling edge of its own clock, raises both resets from time zero, and uses the default offsets. It checks threshold flags only after both clocks have run long enough for the pointers to settle, so synchronizer lag never shows up as a false mismatch.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;

  // Plain binary to reflected Gray code.
  function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  // Gray back to binary by a log-depth prefix XOR.
  function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
    logic [31:0] b;
    b = g;
    for (int s = 1; s < 32; s = s << 1) b = b ^ (b >> s);
    return b;
  endfunction

endpackage

// File: rtl/dcfifo_ptr_sync.sv
module dcfifo_ptr_sync #(
  parameter int W      = 11,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int N = (STAGES < 2) ? 2 : STAGES;

  logic [W-1:0] chain_q [N];

  for (genvar i = 0; i < N; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain_q[0] <= '0;
        else     chain_q[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain_q[i] <= '0;
        else     chain_q[i] <= chain_q[i-1];
      end
    end
  end

  assign q = chain_q[N-1];
endmodule

// File: rtl/dcfifo_dp_ram.sv
module dcfifo_dp_ram #(
  parameter int W  = 36,
  parameter int AW = 10
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          rclk,
  input  logic          rrst,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];
  logic [W-1:0] rdata_q;

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Registered read with enable: this register is the prefetch output stage.
  always_ff @(posedge rclk) begin
    if (rrst)    rdata_q <= '0;
    else if (re) rdata_q <= mem[raddr];
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/dcfifo_wr_side.sv
module dcfifo_wr_side
  import dcfifo_pkg::*;
#(
  parameter int AW     = 10,
  parameter int AF_OFS = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW:0]   rgray_sync,
  output logic          wr_fire,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wgray,
  output logic          in_ready,
  output logic          almost_full_n
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam int AF_AT = DEPTH - AF_OFS;

  logic [PW-1:0] wbin_q, wbin_nx, rbin, fill_nx, fill_now;
  logic [PW-1:0] wgray_q;
  logic          ir_q, af_n_q;

  assign wr_fire  = wr_en & ir_q;
  assign wbin_nx  = wbin_q + PW'(wr_fire);
  assign rbin     = PW'(gray_to_bin(32'(rgray_sync)));
  assign fill_nx  = wbin_nx - rbin;
  assign fill_now = wbin_q - rbin;

  always_ff @(posedge clk) begin
    if (rst) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      ir_q    <= 1'b1;
      af_n_q  <= 1'b1;
    end else begin
      wbin_q  <= wbin_nx;
      wgray_q <= PW'(bin_to_gray(32'(wbin_nx)));
      ir_q    <= (fill_nx != PW'(DEPTH));
      af_n_q  <= (32'(fill_nx) < 32'(AF_AT));
    end
  end

  assign waddr         = wbin_q[AW-1:0];
  assign wgray         = wgray_q;
  assign in_ready      = ir_q;
  assign almost_full_n = af_n_q;

  // R10: the write side's view of the count never passes capacity
  assert_fill_bound_R10: assert property (@(posedge clk) disable iff (rst)
    32'(fill_now) <= 32'(DEPTH));
  // R7: a strobe against a full flag leaves the write pointer alone
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !ir_q) |=> $stable(wbin_q));
  // R6: full always implies almost-full
  assert_full_in_af_R6: assert property (@(posedge clk) disable iff (rst)
    !ir_q |-> !af_n_q);
  // R9: the pointer sent across flips at most one bit per cycle
  assert_gray_step_R9: assert property (@(posedge clk) disable iff (rst)
    $countones(wgray_q ^ $past(wgray_q)) <= 1);
endmodule

// File: rtl/dcfifo_rd_side.sv
module dcfifo_rd_side
  import dcfifo_pkg::*;
#(
  parameter int AW     = 10,
  parameter int AE_OFS = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic [AW:0]   wgray_sync,
  output logic          ram_re,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   cgray,
  output logic          out_ready,
  output logic          almost_empty_n
);
  localparam int PW = AW + 1;

  // fbin: next memory slot to fetch; cbin: words consumed through rd_en.
  logic [PW-1:0] fbin_q, cbin_q, fbin_nx, cbin_nx, wbin, held_nx;
  logic [PW-1:0] cgray_q;
  logic          ov_q, ae_n_q;
  logic          pop, avail, load;

  assign wbin    = PW'(gray_to_bin(32'(wgray_sync)));
  assign pop     = rd_en & ov_q;
  assign avail   = (wbin != fbin_q);
  assign load    = avail & (~ov_q | pop);
  assign fbin_nx = fbin_q + PW'(load);
  assign cbin_nx = cbin_q + PW'(pop);
  assign held_nx = wbin - cbin_nx;

  always_ff @(posedge clk) begin
    if (rst) begin
      fbin_q  <= '0;
      cbin_q  <= '0;
      cgray_q <= '0;
      ov_q    <= 1'b0;
      ae_n_q  <= 1'b0;
    end else begin
      fbin_q  <= fbin_nx;
      cbin_q  <= cbin_nx;
      cgray_q <= PW'(bin_to_gray(32'(cbin_nx)));
      ov_q    <= load | (ov_q & ~pop);
      ae_n_q  <= (32'(held_nx) > 32'(AE_OFS));
    end
  end

  assign ram_re         = load;
  assign raddr          = fbin_q[AW-1:0];
  assign cgray          = cgray_q;
  assign out_ready      = ov_q;
  assign almost_empty_n = ae_n_q;

  // R2: an idle output stage picks up an available word on the next edge
  assert_prefetch_R2: assert property (@(posedge clk) disable iff (rst)
    (avail && !ov_q) |=> ov_q);
  // R8: a strobe on an empty output consumes nothing
  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !ov_q) |=> $stable(cbin_q));
  // R5: above the almost-empty level a word must be on show
  assert_ae_needs_word_R5: assert property (@(posedge clk) disable iff (rst)
    ae_n_q |-> ov_q);
  // R9: consumed pointer sent across flips at most one bit per cycle
  assert_gray_step_rd_R9: assert property (@(posedge clk) disable iff (rst)
    $countones(cgray_q ^ $past(cgray_q)) <= 1);
endmodule

// File: rtl/dcfifo_prefetch.sv
module dcfifo_prefetch #(
  parameter int WIDTH       = 36,
  parameter int AW          = 10,
  parameter int AE_OFS      = 8,
  parameter int AF_OFS      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             wclk,
  input  logic             wrst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wdata,
  output logic             in_ready,
  output logic             almost_full_n,
  input  logic             rclk,
  input  logic             rrst,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rdata,
  output logic             out_ready,
  output logic             almost_empty_n
);
  localparam int PW = AW + 1;

  logic          wr_fire, ram_re;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wgray, cgray, wgray_at_r, cgray_at_w;

  dcfifo_wr_side #(.AW(AW), .AF_OFS(AF_OFS)) u_wr (
    .clk(wclk), .rst(wrst), .wr_en(wr_en), .rgray_sync(cgray_at_w),
    .wr_fire(wr_fire), .waddr(waddr), .wgray(wgray),
    .in_ready(in_ready), .almost_full_n(almost_full_n)
  );

  dcfifo_ptr_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_w2r (
    .clk(rclk), .rst(rrst), .d(wgray), .q(wgray_at_r)
  );

  dcfifo_ptr_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_r2w (
    .clk(wclk), .rst(wrst), .d(cgray), .q(cgray_at_w)
  );

  dcfifo_rd_side #(.AW(AW), .AE_OFS(AE_OFS)) u_rd (
    .clk(rclk), .rst(rrst), .rd_en(rd_en), .wgray_sync(wgray_at_r),
    .ram_re(ram_re), .raddr(raddr), .cgray(cgray),
    .out_ready(out_ready), .almost_empty_n(almost_empty_n)
  );

  dcfifo_dp_ram #(.W(WIDTH), .AW(AW)) u_ram (
    .wclk(wclk), .we(wr_fire), .waddr(waddr), .wdata(wdata),
    .rclk(rclk), .rrst(rrst), .re(ram_re), .raddr(raddr), .rdata(rdata)
  );

  // R3: a shown word holds until it is consumed
  assert_hold_word_R3: assert property (@(posedge rclk) disable iff (rrst)
    (out_ready && !rd_en) |=> $stable(rdata));
  // R1: read-side reset forces the empty indication
  assert_reset_empty_R1: assert property (@(posedge rclk)
    $past(rrst) |-> (!out_ready && !almost_empty_n));
endmodule

// File: tb/dcfifo_prefetch_tb.sv
module dcfifo_prefetch_tb;
  localparam int CLK_PERIOD  = 10;
  localparam int RCLK_PERIOD = 14;
  localparam int WIDTH = 36;
  localparam int AW    = 10;
  localparam int DEPTH = 1 << AW;
  localparam int AE    = 8;
  localparam int AF    = 8;

  logic wclk = 0, rclk = 0;
  logic wrst = 1, rrst = 1;
  logic wr_en = 0, rd_en = 0;
  logic [WIDTH-1:0] wdata = '0;
  logic [WIDTH-1:0] rdata;
  logic in_ready, almost_full_n, out_ready, almost_empty_n;

  int checks = 0, fails = 0;
  logic [WIDTH-1:0] model [$];

  always #(CLK_PERIOD/2)  wclk = ~wclk;
  always #(RCLK_PERIOD/2) rclk = ~rclk;

  dcfifo_prefetch #(.WIDTH(WIDTH), .AW(AW), .AE_OFS(AE), .AF_OFS(AF)) u_dut (
    .wclk(wclk), .wrst(wrst), .wr_en(wr_en), .wdata(wdata),
    .in_ready(in_ready), .almost_full_n(almost_full_n),
    .rclk(rclk), .rrst(rrst), .rd_en(rd_en), .rdata(rdata),
    .out_ready(out_ready), .almost_empty_n(almost_empty_n)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected {out_ready, almost_empty_n, almost_full_n, in_ready} for a count.
  function automatic logic [3:0] exp_flags(input int n);
    return {n > 0, n > AE, n < DEPTH - AF, n < DEPTH};
  endfunction

  task automatic check_flags(input string req);
    logic [3:0] got;
    got = {out_ready, almost_empty_n, almost_full_n, in_ready};
    check(got == exp_flags(model.size()), req, 64'(got), 64'(exp_flags(model.size())));
  endtask

  task automatic settle();
    repeat (14) @(negedge rclk);
  endtask

  task automatic write_words(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge wclk);
      wr_en = 1'b1;
      wdata = {$urandom, 4'($urandom)};
      if (in_ready) model.push_back(wdata);
    end
    @(negedge wclk);
    wr_en = 1'b0;
  endtask

  task automatic read_words(input int n, input string req);
    int got = 0;
    while (got < n) begin
      @(negedge rclk);
      if (out_ready) begin
        check(rdata == model[0], req, 64'(rdata), 64'(model[0]));
        void'(model.pop_front());
        rd_en = 1'b1;
        got++;
      end else rd_en = 1'b0;
    end
    @(negedge rclk);
    rd_en = 1'b0;
  endtask

  task automatic rand_writer(input int cycles, input int pct);
    for (int i = 0; i < cycles; i++) begin
      @(negedge wclk);
      wr_en = (($urandom % 100) < pct);
      wdata = {$urandom, 4'($urandom)};
      if (wr_en && in_ready) model.push_back(wdata);
    end
    @(negedge wclk);
    wr_en = 1'b0;
  endtask

  task automatic rand_reader(input int cycles, input int pct);
    for (int i = 0; i < cycles; i++) begin
      @(negedge rclk);
      rd_en = (($urandom % 100) < pct);
      if (rd_en && out_ready) begin
        check(rdata == model[0], "R4 random order", 64'(rdata), 64'(model[0]));
        void'(model.pop_front());
      end
    end
    @(negedge rclk);
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge wclk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [WIDTH-1:0] first;
    void'($urandom(32'd20240611));
    repeat (2) @(negedge rclk);
    check_flags("R1 flags during reset");
    repeat (4) @(negedge wclk);
    wrst = 1'b0;
    @(negedge rclk);
    rrst = 1'b0;
    settle();
    check_flags("R1 flags after reset");

    // R8: reads against an empty block are ignored
    rd_en = 1'b1;
    repeat (10) @(negedge rclk);
    rd_en = 1'b0;
    check(out_ready == 1'b0, "R8 empty read", 64'(out_ready), 64'd0);

    // R2: first word falls through without a read
    write_words(1);
    first = model[0];
    settle();
    check(out_ready == 1'b1, "R2 prefetch ready", 64'(out_ready), 64'd1);
    check(rdata == first, "R2 prefetch data / R8 nothing lost", 64'(rdata), 64'(first));
    check_flags("R5 one word");

    // R3: shown word holds while more arrive
    write_words(AE - 1);
    settle();
    check(rdata == first, "R3 hold", 64'(rdata), 64'(first));
    check_flags("R5 count equal to X");
    write_words(1);
    settle();
    check_flags("R5 count X+1");

    // R6 thresholds
    write_words(DEPTH - AF - 1 - model.size());
    settle();
    check_flags("R6 count below almost-full");
    write_words(1);
    settle();
    check_flags("R6 count at DEPTH-Y");
    write_words(DEPTH - 1 - model.size());
    settle();
    check_flags("R6 count DEPTH-1");
    write_words(1);
    settle();
    check(model.size() == DEPTH, "R10 capacity", 64'(model.size()), 64'(DEPTH));
    check_flags("R6 full");

    // R7: writes while full are dropped
    write_words(20);
    settle();
    check(model.size() == DEPTH, "R7 model unchanged", 64'(model.size()), 64'(DEPTH));
    read_words(1, "R4 first out");
    settle();
    check_flags("R9 late release of full");
    read_words(DEPTH - 1, "R7 R4 drain order");
    settle();
    check(out_ready == 1'b0, "R7 no extra word", 64'(out_ready), 64'd0);
    check_flags("R5 empty again");

    // Random traffic, writer-heavy then reader-heavy
    fork
      rand_writer(4000, 80);
      rand_reader(2800, 40);
    join
    settle();
    check_flags("R5 R6 after write-heavy");
    fork
      rand_writer(3000, 30);
      rand_reader(2200, 85);
    join
    settle();
    check_flags("R5 R6 after read-heavy");
    read_words(model.size(), "R4 final drain");
    settle();
    check_flags("R1 final empty");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule